// File: doc/BRIEF.md
# Multiplexed LCD Drive Sequencer

This block produces the time-slot sequence that drives a multiplexed segment display. It divides each frame into time slots. In every slot it picks one of four voltage levels, as a 2-bit digital code, for each backplane line and each segment line. The analog level generation and output switches sit downstream and turn these codes into voltages. The block supports four drive modes, from a single backplane up to four. In the two-backplane mode it also offers a half-bias scheme as an option.

Each frame is split into two halves. The first half walks through the used backplane rows in order. The second half walks through them again with every level inverted, so that the net DC across each pixel is zero. A 3-bit rate code sets the slot length in clock cycles, and with it the frame rate. An active-low frame marker lets several drivers in a cascade stay in step. A falling edge on the frame-marker input restarts the local frame at once. Changes to the mode, bias and rate inputs are applied only when a new frame begins.

Top module: `lcd_mux_sequencer`

## Requirements
- R1: `mode` selects the number of used rows N: 0 gives 1 row, 1 gives 2, 2 gives 3 and 3 gives 4. A frame has 2N slots. Slot s with s < N scans row s with normal polarity, and slot N+s scans row s again with inverted polarity.
- R2: Level codes are 00 for ground, 01 for the low level (1/3, or 1/2 under half bias), 10 for the 2/3 level and 11 for full supply. Backplane k drives two bits, `bp_lvl[2k+1:2k]`. The scanned backplane drives 11 in the first half of the frame and 00 in the second half. Under 1/3 bias an unscanned used backplane drives 01 in the first half and 10 in the second half. Under half bias it drives 01 in both halves. A backplane with index N or above drives 00.
- R3: Under 1/3 bias, segment j reads bit `seg_bits[4j+r]`, where r is the scanned row. If that bit is 1 (lit), the segment drives 00 in the first half and 11 in the second half. If the bit is 0 (dark), it drives 10 in the first half and 01 in the second half. Segment j's code appears on `seg_lvl[2j+1:2j]`.
- R4: Two-level segment drive applies in mode 0, and in mode 1 when `bias_half` is 1. In two-level drive a lit segment drives 00 and then 11, and a dark segment drives 11 and then 00.
- R5: `bias_half` has no effect in modes 0, 2 and 3.
- R6: A slot lasts SLOT_CYC_MAX − SLOT_STEP·min(`rate_sel`, 6) clock cycles, so code 7 behaves like code 6. With the default values this gives 10 cycles for code 0, falling to 4 cycles for codes 6 and 7.
- R7: `sync_n` is low for every cycle of the first slot of each frame and high in all other slots.
- R8: A falling edge on `sync_in_n` restarts the frame. The restart happens at the first clock edge that samples the input low, and the first cycle of slot 0 appears on the outputs at the following edge. Holding the input low does not restart the frame again.
- R9: `mode`, `bias_half` and `rate_sel` are captured only when a frame starts, either by wrapping from the last slot or by a restart. A frame that is already running keeps its settings when these inputs change.
- R10: While `rst` is high, all level outputs are 00, `sync_n` is high and the configuration inputs are captured. The first edge after reset is released presents the first cycle of slot 0.
- R11: Bits of `seg_bits` for rows N and above have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Operating clock |
| rst | input | 1 | Synchronous active-high reset |
| mode | input | 2 | Number of used rows minus one |
| bias_half | input | 1 | Selects half bias in the two-row mode |
| rate_sel | input | 3 | Slot-length code (sets the frame rate) |
| seg_bits | input | NSEG*4 | Display bits: four rows per segment, with the row number as the low index |
| sync_in_n | input | 1 | Cascade frame marker input; a falling edge restarts the frame |
| bp_lvl | output | 8 | Level codes for the four backplanes, 2 bits each |
| seg_lvl | output | NSEG*2 | Level codes for the segments, 2 bits each |
| sync_n | output | 1 | Active-low marker, low during slot 0 |

## Verification
The bench predicts every output cycle across whole frames, for each of the four modes under both bias settings and at several rate codes including the saturated code 7. This separates slot-length faults from row-scan faults and from polarity faults. Bit patterns that put opposite values in the unused rows expose any read of rows beyond N. A run that changes the mode and rate partway through a frame shows whether the change waits for the boundary. A cascade restart held low for several cycles, with the mode changed at the same moment, tells a correct single restart apart from a repeated one and from late capture of the configuration.

// File: rtl/lcdseq_pkg.sv
package lcdseq_pkg;
  typedef enum logic [1:0] {
    LV_GND  = 2'b00,
    LV_LOW  = 2'b01,
    LV_HIGH = 2'b10,
    LV_FULL = 2'b11
  } lvl_e;

  typedef enum logic [1:0] {
    MD_ONE   = 2'd0,
    MD_TWO   = 2'd1,
    MD_THREE = 2'd2,
    MD_FOUR  = 2'd3
  } mode_e;

  localparam int MAX_ROWS = 4;
  localparam int RATE_SAT = 6;
endpackage

// File: rtl/lcdseq_frame_timer.sv
module lcdseq_frame_timer
  import lcdseq_pkg::*;
#(
  parameter int SLOT_CYC_MAX = 10,
  parameter int SLOT_STEP    = 1
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] mode_i,
  input  logic       half_i,
  input  logic [2:0] rate_i,
  input  logic       sync_in_n,
  output logic [1:0] row_o,
  output logic       inv_o,
  output logic       two_lvl_o,
  output logic [2:0] rows_o,
  output logic       sync_n_o
);
  localparam int CW = $clog2(SLOT_CYC_MAX + 1);

  logic [CW-1:0] cyc;
  logic [2:0]    slot;
  logic [1:0]    cfg_mode;
  logic [2:0]    cfg_rate;
  logic          cfg_half;
  logic          sync_prev;

  logic [2:0]    n_rows, last_slot, rate_sat;
  logic [CW-1:0] last_cyc;
  logic          restart, slot_end, frame_end;

  always_comb begin
    n_rows    = {1'b0, cfg_mode} + 3'd1;
    last_slot = {cfg_mode, 1'b1};
    rate_sat  = (cfg_rate > 3'(RATE_SAT)) ? 3'(RATE_SAT) : cfg_rate;
    last_cyc  = CW'(SLOT_CYC_MAX - 1 - SLOT_STEP * int'(rate_sat));
    restart   = sync_prev & ~sync_in_n;
    slot_end  = (cyc == last_cyc);
    frame_end = slot_end && (slot == last_slot);
    inv_o     = (slot >= n_rows);
    row_o     = inv_o ? (slot[1:0] - n_rows[1:0]) : slot[1:0];
    two_lvl_o = (cfg_mode == MD_ONE) || ((cfg_mode == MD_TWO) && cfg_half);
    rows_o    = n_rows;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cyc       <= '0;
      slot      <= '0;
      cfg_mode  <= mode_i;
      cfg_rate  <= rate_i;
      cfg_half  <= half_i;
      sync_prev <= 1'b1;
      sync_n_o  <= 1'b1;
    end else begin
      sync_prev <= sync_in_n;
      sync_n_o  <= (slot != 3'd0);
      if (restart || frame_end) begin
        cyc      <= '0;
        slot     <= '0;
        cfg_mode <= mode_i;
        cfg_rate <= rate_i;
        cfg_half <= half_i;
      end else if (slot_end) begin
        cyc  <= '0;
        slot <= slot + 3'd1;
      end else begin
        cyc <= cyc + 1'b1;
      end
    end
  end

  p_slot_in_frame_r1: assert property (@(posedge clk) disable iff (rst)
    slot <= last_slot);

  p_slot_len_r6: assert property (@(posedge clk) disable iff (rst)
    cyc <= last_cyc);

  p_cfg_hold_r9: assert property (@(posedge clk) disable iff (rst)
    !(slot == 3'd0 && cyc == '0) |->
      ($stable(cfg_mode) && $stable(cfg_rate) && $stable(cfg_half)));

  p_ext_restart_r8: assert property (@(posedge clk) disable iff (rst)
    (sync_prev && !sync_in_n) |=> (slot == 3'd0 && cyc == '0));
endmodule

// File: rtl/lcdseq_bp_drv.sv
module lcdseq_bp_drv
  import lcdseq_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst,
  input  logic [1:0]            row_i,
  input  logic                  inv_i,
  input  logic                  two_lvl_i,
  input  logic [2:0]            rows_i,
  output logic [2*MAX_ROWS-1:0] lvl_o
);
  for (genvar k = 0; k < MAX_ROWS; k++) begin : g_bp
    logic [1:0] nxt, q;

    always_comb begin
      if (rows_i <= 3'(k))       nxt = LV_GND;
      else if (row_i == 2'(k))   nxt = inv_i ? LV_GND : LV_FULL;
      else if (two_lvl_i)        nxt = LV_LOW;
      else                       nxt = inv_i ? LV_HIGH : LV_LOW;
    end

    always_ff @(posedge clk) begin
      if (rst) q <= LV_GND;
      else     q <= nxt;
    end

    assign lvl_o[2*k +: 2] = q;
  end
endmodule

// File: rtl/lcdseq_seg_drv.sv
module lcdseq_seg_drv
  import lcdseq_pkg::*;
#(
  parameter int NSEG = 8
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [1:0]               row_i,
  input  logic                     inv_i,
  input  logic                     two_lvl_i,
  input  logic [NSEG*MAX_ROWS-1:0] bits_i,
  output logic [2*NSEG-1:0]        lvl_o
);
  for (genvar j = 0; j < NSEG; j++) begin : g_seg
    logic       lit;
    logic [1:0] nxt, q;

    always_comb begin
      lit = bits_i[j*MAX_ROWS + int'(row_i)];
      if (two_lvl_i) nxt = (lit != inv_i) ? LV_GND : LV_FULL;
      else if (lit)  nxt = inv_i ? LV_FULL : LV_GND;
      else           nxt = inv_i ? LV_LOW : LV_HIGH;
    end

    always_ff @(posedge clk) begin
      if (rst) q <= LV_GND;
      else     q <= nxt;
    end

    assign lvl_o[2*j +: 2] = q;

    p_two_level_r4: assert property (@(posedge clk) disable iff (rst)
      $past(two_lvl_i) |-> (q == LV_GND || q == LV_FULL));
  end
endmodule

// File: rtl/lcd_mux_sequencer.sv
module lcd_mux_sequencer
  import lcdseq_pkg::*;
#(
  parameter int NSEG         = 8,
  parameter int SLOT_CYC_MAX = 10,
  parameter int SLOT_STEP    = 1
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [1:0]               mode,
  input  logic                     bias_half,
  input  logic [2:0]               rate_sel,
  input  logic [NSEG*MAX_ROWS-1:0] seg_bits,
  input  logic                     sync_in_n,
  output logic [2*MAX_ROWS-1:0]    bp_lvl,
  output logic [2*NSEG-1:0]        seg_lvl,
  output logic                     sync_n
);
  logic [1:0] row;
  logic       inv, two_lvl;
  logic [2:0] rows;

  lcdseq_frame_timer #(
    .SLOT_CYC_MAX(SLOT_CYC_MAX),
    .SLOT_STEP   (SLOT_STEP)
  ) u_timer (
    .clk      (clk),
    .rst      (rst),
    .mode_i   (mode),
    .half_i   (bias_half),
    .rate_i   (rate_sel),
    .sync_in_n(sync_in_n),
    .row_o    (row),
    .inv_o    (inv),
    .two_lvl_o(two_lvl),
    .rows_o   (rows),
    .sync_n_o (sync_n)
  );

  lcdseq_bp_drv u_bp (
    .clk      (clk),
    .rst      (rst),
    .row_i    (row),
    .inv_i    (inv),
    .two_lvl_i(two_lvl),
    .rows_i   (rows),
    .lvl_o    (bp_lvl)
  );

  lcdseq_seg_drv #(.NSEG(NSEG)) u_seg (
    .clk      (clk),
    .rst      (rst),
    .row_i    (row),
    .inv_i    (inv),
    .two_lvl_i(two_lvl),
    .bits_i   (seg_bits),
    .lvl_o    (seg_lvl)
  );

  logic [MAX_ROWS-1:0] full_flag;
  always_comb begin
    for (int k = 0; k < MAX_ROWS; k++) full_flag[k] = (bp_lvl[2*k +: 2] == LV_FULL);
  end

  p_single_full_bp_r2: assert property (@(posedge clk) disable iff (rst)
    $countones(full_flag) <= 1);
endmodule

// File: tb/lcd_mux_sequencer_test.sv
module lcd_mux_sequencer_test;
  localparam int NSEG = 8;
  localparam int SMAX = 10;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic                rst = 1'b1;
  logic [1:0]          mode = 2'd0;
  logic                bias_half = 1'b0;
  logic [2:0]          rate_sel = 3'd0;
  logic [NSEG*4-1:0]   seg_bits = '0;
  logic                sync_in_n = 1'b1;
  logic [7:0]          bp_lvl;
  logic [NSEG*2-1:0]   seg_lvl;
  logic                sync_n;

  lcd_mux_sequencer #(.NSEG(NSEG), .SLOT_CYC_MAX(SMAX), .SLOT_STEP(1)) uut (
    .clk(clk), .rst(rst), .mode(mode), .bias_half(bias_half), .rate_sel(rate_sel),
    .seg_bits(seg_bits), .sync_in_n(sync_in_n), .bp_lvl(bp_lvl), .seg_lvl(seg_lvl),
    .sync_n(sync_n)
  );

  typedef struct {
    logic [7:0]        bp;
    logic [NSEG*2-1:0] seg;
    logic              sy;
    string             tag;
  } exp_t;

  exp_t q[$];
  int   n_chk = 0;
  int   n_fail = 0;
  bit   mon_en = 1'b0;
  bit   done = 1'b0;

  // Expected output for one slot, written from R1..R4, R7 and R11
  function automatic exp_t model(int m, bit half, int s, logic [NSEG*4-1:0] bits, string tag);
    int   n   = m + 1;
    bit   inv = (s >= n);
    int   row = (s >= n) ? s - n : s;
    bit   two = (m == 0) || (m == 1 && half);
    exp_t e;
    e.tag = tag;
    e.sy  = (s != 0);
    for (int k = 0; k < 4; k++) begin
      if (k >= n)        e.bp[2*k +: 2] = 2'b00;
      else if (k == row) e.bp[2*k +: 2] = inv ? 2'b00 : 2'b11;
      else if (two)      e.bp[2*k +: 2] = 2'b01;
      else               e.bp[2*k +: 2] = inv ? 2'b10 : 2'b01;
    end
    for (int j = 0; j < NSEG; j++) begin
      bit d = bits[j*4 + row];
      if (two)   e.seg[2*j +: 2] = (d != inv) ? 2'b00 : 2'b11;
      else if (d) e.seg[2*j +: 2] = inv ? 2'b11 : 2'b00;
      else       e.seg[2*j +: 2] = inv ? 2'b01 : 2'b10;
    end
    return e;
  endfunction

  function automatic int slot_len(int pre);
    return SMAX - ((pre > 6) ? 6 : pre);   // R6
  endfunction

  task automatic push_frames(int m, bit half, int pre, logic [NSEG*4-1:0] bits, int nf, string tag);
    for (int f = 0; f < nf; f++)
      for (int s = 0; s < 2*(m+1); s++)
        for (int c = 0; c < slot_len(pre); c++)
          q.push_back(model(m, half, s, bits, tag));
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  // Monitor: pops one expected item per cycle, samples 2 ns after the edge
  always begin
    @(posedge clk);
    #2;
    if (mon_en && q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      n_chk++;
      if (bp_lvl !== e.bp || seg_lvl !== e.seg || sync_n !== e.sy) begin
        n_fail++;
        $display("FAIL %s: bp=%h seg=%h sync=%b expected bp=%h seg=%h sync=%b",
                 e.tag, bp_lvl, seg_lvl, sync_n, e.bp, e.seg, e.sy);
      end
    end
  end

  task automatic start(int m, bit half, int pre, logic [NSEG*4-1:0] bits);
    @(negedge clk);
    mon_en    = 1'b0;
    q.delete();
    mode      = m[1:0];
    bias_half = half;
    rate_sel  = pre[2:0];
    seg_bits  = bits;
    sync_in_n = 1'b1;
    rst       = 1'b1;
    repeat (3) @(negedge clk);
    n_chk++;   // R10 reset state
    if (bp_lvl !== 8'h00 || seg_lvl !== '0 || sync_n !== 1'b1) begin
      n_fail++;
      $display("FAIL R10: bp=%h seg=%h sync=%b expected bp=00 seg=0 sync=1", bp_lvl, seg_lvl, sync_n);
    end
    rst    = 1'b0;
    mon_en = 1'b1;
  endtask

  task automatic drain();
    while (q.size() > 0) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: run did not finish, expected completion");
    finish_run();
  end

  initial begin
    // R1 R2 R3 R7 R10: four rows, 1/3 bias, rate code 3
    start(3, 0, 3, 32'hA5C3_1E69);
    push_frames(3, 0, 3, 32'hA5C3_1E69, 2, "R1/R3/R7");
    drain();

    // R5 R11: three rows with half bias requested (ignored), row-3 bits set
    start(2, 1, 0, 32'h8F70_F08E);
    push_frames(2, 1, 0, 32'h8F70_F08E, 2, "R5/R11");
    drain();

    // R2 R3: two rows, 1/3 bias, rate code 6
    start(1, 0, 6, 32'h3C96_5AE1);
    push_frames(1, 0, 6, 32'h3C96_5AE1, 3, "R2/R3");
    drain();

    // R4 R6: two rows, half bias, saturated rate code 7
    start(1, 1, 7, 32'h3C96_5AE1);
    push_frames(1, 1, 7, 32'h3C96_5AE1, 3, "R4/R6");
    drain();

    // R4 R5 R11: single row, half bias ignored, upper-row bits opposite
    start(0, 1, 5, 32'hE1D2_B487);
    push_frames(0, 1, 5, 32'hE1D2_B487, 4, "R4/R11");
    drain();

    // R9: settings change in the middle of the last pushed frame
    start(3, 0, 2, 32'h1234_ABCD);
    push_frames(3, 0, 2, 32'h1234_ABCD, 2, "R9");
    while (q.size() > (8 * slot_len(2)) / 2) @(negedge clk);
    mode      = 2'd1;
    bias_half = 1'b1;
    rate_sel  = 3'd4;
    push_frames(1, 1, 4, 32'h1234_ABCD, 2, "R9");
    drain();

    // R8 R9: external restart held low for three cycles, mode changed with it
    start(2, 0, 4, 32'h5A5A_C3C3);
    push_frames(2, 0, 4, 32'h5A5A_C3C3, 2, "R8");
    repeat (15) @(negedge clk);
    mon_en    = 1'b0;
    q.delete();
    sync_in_n = 1'b0;
    mode      = 2'd3;
    @(negedge clk);
    push_frames(3, 0, 4, 32'h5A5A_C3C3, 2, "R8/R9");
    mon_en = 1'b1;
    repeat (2) @(negedge clk);
    sync_in_n = 1'b1;
    drain();

    finish_run();
  end
endmodule